// File: doc/BRIEF.md
# Single-Channel Serial Port with Status-Flag Control

This block is one asynchronous serial channel with a small register interface. Software turns the channel on through a control register. A status register holds the two direction enables and a set of flags. The block serializes bytes written to its transmit register onto `txd`, and it deserializes frames arriving on `rxd` into a one-byte holding register. Frames are 8N1: one start bit (0), eight data bits with the least significant bit first, and one stop bit (1). Each bit lasts `CLKS_PER_BIT` clock cycles, which must be even and at least 4.

The receive side holds exactly one byte. While that byte is unread, every further frame is dropped. Turning the whole channel off, or turning off either direction, forces a fixed set of flags and interrupt levels to their quiet values. Three level interrupts form an indexed group: bit 0 is error, bit 1 is receive, bit 2 is transmit.

Registers (selected by `addr`):
- 0: control. Bit 0 is the channel-on bit.
- 1: status, holding these bits:
  - bit 0: receive enable (RW)
  - bit 1: transmit enable (RW)
  - bit 2: data available (RO)
  - bit 3: framing error (a 0 written clears it)
  - bit 4: parity error (a 0 written clears it)
  - bit 5: transmit busy/full (RO)
  - bit 6: transmit empty (RO)
  - bit 7: receiver idle (RO)
- 2: receive data (read).
- 3: transmit data (write).

Reads are registered: `rdata` shows the selected value after the clock edge that samples `rd_en`.

Top module: `serial_port_ctl`

## Requirements
- R1: After reset the status register reads 0xC0 (only receiver-idle and transmit-empty set), the control bit reads 0, `irq` is 3'b000 and `txd` is 1.
- R2: Reads return the layout above: control in bit 0 of address 0, and status with bit 0 receive enable through bit 7 receiver idle; the value appears on `rdata` one cycle after the read strobe.
- R3: A write to address 3 while on, transmit-enabled and not busy starts a frame on `txd` in the cycle after the write. The frame is a start bit 0, then data bits 0..7, then stop bit 1, each `CLKS_PER_BIT` cycles long. The same edge sets busy and clears empty. A write made under any other condition is ignored.
- R4: 10*`CLKS_PER_BIT` cycles after the loading edge, busy clears and empty sets. If the channel is still on and transmit is still enabled, `irq[2]` rises at that edge.
- R5: The edge that samples the stop bit stores the frame. That edge comes 2 + 9.5*`CLKS_PER_BIT` cycles after the first edge that sees the start bit. The byte is stored only while on, receive-enabled and with data-available clear. Storing it sets data-available and `irq[1]`.
- R6: While data-available is set, arriving frames are dropped and the held byte is unchanged.
- R7: A read of address 2 returns the held byte and clears data-available and `irq[1]`.
- R8: A frame whose stop bit samples 0 sets framing error and `irq[0]`. The byte is still stored if the holding register is free.
- R9: A status write clears each error flag whose bit is written 0. `irq[0]` clears only when bits 3 and 4 are both written 0.
- R10: While the channel is off, `irq[2:1]`, data-available, both error flags and busy are forced to 0, and empty and receiver-idle are forced to 1. A frame in flight on either side is abandoned, and `txd` returns to 1.
- R11: While receive is disabled, `irq[1]`, data-available and both error flags are forced to 0, and no frame is received.
- R12: While transmit is disabled, `irq[2]` and busy are forced to 0, and empty is forced to 1. A frame in flight stops, and `txd` returns to 1 at the same edge.
- R13: Receiver-idle reads 0 from 2 cycles after the first edge that sees a falling start bit until the stop-bit sampling edge. A falling edge is needed to start a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| irq | output | 3 | Level interrupts: [0] error, [1] receive, [2] transmit |

## Verification
A behavioural model in the bench follows the flags, interrupt levels, read data and the expected `txd` bit on every clock. The receive path is tried with four patterns, each telling a different behaviour apart:
- a clean frame into an empty holder, which shows storage timing;
- two frames back to back without a read, which separates dropping from overwriting;
- a frame with a low stop bit, which shows that storage and error flagging are independent;
- frames sent while the channel or receiver is off, which shows the gating.

On the transmit side, the bench sends a write while busy and a write while the channel is off, which show that both are ignored. It also turns transmit off and then the channel off in the middle of a frame. These cases tell a clean completion apart from a forced abort, both on the line and on the interrupt.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int BYTE_W = 8;
  localparam int FRAME_BITS = BYTE_W + 2;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_RXD  = 2'd2,
    A_TXD  = 2'd3
  } sp_addr_e;

  localparam int S_RXEN  = 0;
  localparam int S_TXEN  = 1;
  localparam int S_AVAIL = 2;
  localparam int S_FERR  = 3;
  localparam int S_PERR  = 4;
  localparam int S_FULL  = 5;
  localparam int S_EMPTY = 6;
  localparam int S_RIDLE = 7;

  localparam int IRQ_ERR = 0;
  localparam int IRQ_RX  = 1;
  localparam int IRQ_TX  = 2;
  localparam int IRQ_N   = 3;
endpackage

// File: rtl/sp_tx.sv
module sp_tx import sp_pkg::*; #(
  parameter int CPB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              kill,
  input  logic [BYTE_W-1:0] data,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int CW = $clog2(CPB);
  localparam int NW = $clog2(FRAME_BITS);

  logic [CW-1:0]     cnt_q;
  logic [NW-1:0]     n_q;
  logic [BYTE_W-1:0] sh_q;
  logic              busy_q, txd_q;
  logic              bit_end;

  assign bit_end = (cnt_q == CW'(CPB - 1));
  assign done    = busy_q && bit_end && (n_q == NW'(FRAME_BITS - 1)) && !kill;
  assign txd     = txd_q;
  assign busy    = busy_q;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      cnt_q  <= '0;
      n_q    <= '0;
      if (rst) sh_q <= '0;
    end else if (!busy_q) begin
      if (load) begin
        busy_q <= 1'b1;
        txd_q  <= 1'b0;
        sh_q   <= data;
        cnt_q  <= '0;
        n_q    <= '0;
      end
    end else if (bit_end) begin
      cnt_q <= '0;
      if (n_q == NW'(FRAME_BITS - 1)) begin
        busy_q <= 1'b0;
      end else begin
        txd_q <= (n_q == NW'(BYTE_W)) ? 1'b1 : sh_q[0];
        sh_q  <= {1'b0, sh_q[BYTE_W-1:1]};
        n_q   <= n_q + 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R12: an idle serializer always holds the line high
  p_idle_line_high_r12: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> txd_q);
endmodule

// File: rtl/sp_rx.sv
module sp_rx import sp_pkg::*; #(
  parameter int CPB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              rxd,
  output logic              busy,
  output logic              done,
  output logic              ferr,
  output logic [BYTE_W-1:0] data
);
  localparam int FIRST_WAIT = CPB + CPB / 2 - 1;
  localparam int CW = $clog2(FIRST_WAIT + 1);
  localparam int NW = $clog2(BYTE_W + 1);

  logic              s1_q, s2_q, s3_q;
  logic              busy_q;
  logic [CW-1:0]     cnt_q;
  logic [NW-1:0]     n_q;
  logic [BYTE_W-1:0] sh_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0) && (n_q == NW'(BYTE_W)) && !clr;
  assign ferr = !s2_q;
  assign data = sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      n_q    <= '0;
      sh_q   <= '0;
    end else if (clr) begin
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (!s2_q && s3_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(FIRST_WAIT);
        n_q    <= '0;
      end
    end else if (cnt_q == '0) begin
      if (n_q == NW'(BYTE_W)) begin
        busy_q <= 1'b0;
      end else begin
        sh_q  <= {s2_q, sh_q[BYTE_W-1:1]};
        n_q   <= n_q + 1'b1;
        cnt_q <= CW'(CPB - 1);
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/serial_port_ctl.sv
module serial_port_ctl import sp_pkg::*; #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              rxd,
  output logic              txd,
  output logic [IRQ_N-1:0]  irq
);
  logic on_q, rxen_q, txen_q, avail_q, ferr_q, perr_q, full_q, empty_q;
  logic [BYTE_W-1:0] rxbuf_q, rdata_q;
  logic [IRQ_N-1:0]  irq_q;

  logic wr_ctrl, wr_stat, wr_txd, rd_rxd;
  logic on_n, rxen_n, txen_n;
  logic tx_load, tx_kill, tx_busy, tx_done;
  logic rx_clr, rx_busy, rx_done, rx_ferr;
  logic [BYTE_W-1:0] rx_byte, stat_v;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_txd  = wr_en && (addr == A_TXD);
  assign rd_rxd  = rd_en && (addr == A_RXD);

  assign on_n   = wr_ctrl ? wdata[0]      : on_q;
  assign rxen_n = wr_stat ? wdata[S_RXEN] : rxen_q;
  assign txen_n = wr_stat ? wdata[S_TXEN] : txen_q;

  assign tx_load = wr_txd && on_q && txen_q && !full_q;
  assign tx_kill = !(on_n && txen_n);
  assign rx_clr  = !(on_n && rxen_n);

  always_comb begin
    stat_v          = '0;
    stat_v[S_RXEN]  = rxen_q;
    stat_v[S_TXEN]  = txen_q;
    stat_v[S_AVAIL] = avail_q;
    stat_v[S_FERR]  = ferr_q;
    stat_v[S_PERR]  = perr_q;
    stat_v[S_FULL]  = full_q;
    stat_v[S_EMPTY] = empty_q;
    stat_v[S_RIDLE] = !rx_busy;
  end

  sp_tx #(.CPB(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .kill(tx_kill), .data(wdata),
    .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  sp_rx #(.CPB(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst(rst), .clr(rx_clr), .rxd(rxd),
    .busy(rx_busy), .done(rx_done), .ferr(rx_ferr), .data(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q    <= 1'b0;
      rxen_q  <= 1'b0;
      txen_q  <= 1'b0;
      avail_q <= 1'b0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      rxbuf_q <= '0;
      rdata_q <= '0;
      irq_q   <= '0;
    end else begin
      on_q   <= on_n;
      rxen_q <= rxen_n;
      txen_q <= txen_n;
      if (rd_en) begin
        case (sp_addr_e'(addr))
          A_CTRL:  rdata_q <= {{(BYTE_W-1){1'b0}}, on_q};
          A_STAT:  rdata_q <= stat_v;
          A_RXD:   rdata_q <= rxbuf_q;
          default: rdata_q <= '0;
        endcase
      end
      if (wr_stat && !wdata[S_FERR]) ferr_q <= 1'b0;
      if (wr_stat && !wdata[S_PERR]) perr_q <= 1'b0;
      if (wr_stat && !wdata[S_FERR] && !wdata[S_PERR]) irq_q[IRQ_ERR] <= 1'b0;
      if (tx_load) begin
        full_q  <= 1'b1;
        empty_q <= 1'b0;
      end
      if (tx_done) begin
        full_q  <= 1'b0;
        empty_q <= 1'b1;
        if (on_q && txen_q) irq_q[IRQ_TX] <= 1'b1;
      end
      if (rd_rxd) begin
        avail_q       <= 1'b0;
        irq_q[IRQ_RX] <= 1'b0;
      end
      if (rx_done) begin
        if (rx_ferr) begin
          ferr_q         <= 1'b1;
          irq_q[IRQ_ERR] <= 1'b1;
        end
        if (!avail_q) begin
          rxbuf_q       <= rx_byte;
          avail_q       <= 1'b1;
          irq_q[IRQ_RX] <= 1'b1;
        end
      end
      if (!on_n) begin
        irq_q[IRQ_RX] <= 1'b0;
        irq_q[IRQ_TX] <= 1'b0;
        avail_q <= 1'b0;
        ferr_q  <= 1'b0;
        perr_q  <= 1'b0;
        full_q  <= 1'b0;
        empty_q <= 1'b1;
      end
      if (!rxen_n) begin
        irq_q[IRQ_RX] <= 1'b0;
        avail_q <= 1'b0;
        ferr_q  <= 1'b0;
        perr_q  <= 1'b0;
      end
      if (!txen_n) begin
        irq_q[IRQ_TX] <= 1'b0;
        full_q  <= 1'b0;
        empty_q <= 1'b1;
      end
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

  // R4: the busy flag and the serializer agree at all times
  p_full_matches_tx_r4: assert property (@(posedge clk) disable iff (rst)
    full_q == tx_busy);
  // R4: the transmit interrupt rises only at the edge where a frame ends
  p_txirq_at_end_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q[IRQ_TX]) |-> ($past(tx_busy) && !tx_busy));
  // R5: the receive interrupt rises together with data-available
  p_rxirq_with_data_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q[IRQ_RX]) |-> avail_q);
  // R6: a held byte is never replaced
  p_hold_byte_r6: assert property (@(posedge clk) disable iff (rst)
    avail_q |=> $stable(rxbuf_q));
  // R7: reading the data register empties the holder
  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_rxd && !rx_done) |=> (!avail_q && !irq_q[IRQ_RX]));
  // R10: an off channel shows only quiet flags
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !on_q |-> (!avail_q && !full_q && empty_q && !irq_q[IRQ_RX] && !irq_q[IRQ_TX] && !rx_busy));
endmodule

// File: tb/test_serial_port_ctl.sv
module test_serial_port_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int CPB = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd;
  logic [2:0] irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  serial_port_ctl #(.CLKS_PER_BIT(CPB)) i_serial_port_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int cyc = 0;
  bit m_on, m_rxen, m_txen, m_avail, m_ferr, m_perr, m_full, m_empty;
  bit o_on, o_txen, o_avail;
  logic [2:0] m_irq;
  logic [7:0] m_rxbuf, m_rdata, m_txbyte, m_stat;
  bit m_txb, m_rxb;
  int m_txs, m_rxe;
  bit m_arm = 1'b0;
  int m_rxa;
  logic [7:0] m_rxbyte;
  bit m_rxbad;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      m_on = 0; m_rxen = 0; m_txen = 0; m_avail = 0; m_ferr = 0; m_perr = 0;
      m_full = 0; m_empty = 1; m_irq = 3'b000; m_rxbuf = 8'h00; m_rdata = 8'h00;
      m_txb = 0; m_rxb = 0;
    end else begin
      o_on = m_on; o_txen = m_txen; o_avail = m_avail;
      m_stat = {~m_rxb, m_empty, m_full, m_perr, m_ferr, m_avail, m_txen, m_rxen};
      if (rd_en) begin
        case (addr)
          2'd0: m_rdata = {7'b0, m_on};
          2'd1: m_rdata = m_stat;
          2'd2: m_rdata = m_rxbuf;
          default: m_rdata = 8'h00;
        endcase
      end
      if (wr_en) begin
        case (addr)
          2'd0: m_on = wdata[0];
          2'd1: begin
            m_rxen = wdata[0]; m_txen = wdata[1];
            if (!wdata[3]) m_ferr = 0;
            if (!wdata[4]) m_perr = 0;
            if (!wdata[3] && !wdata[4]) m_irq[0] = 1'b0;
          end
          2'd3: if (o_on && o_txen && !m_full) begin
            m_full = 1; m_empty = 0; m_txb = 1; m_txs = cyc; m_txbyte = wdata;
          end
          default: ;
        endcase
      end
      if (!(m_on && m_txen)) m_txb = 0;
      if (!(m_on && m_rxen)) m_rxb = 0;
      if (m_txb && cyc == m_txs + 10*CPB) begin
        m_txb = 0; m_full = 0; m_empty = 1;
        if (o_on && o_txen) m_irq[2] = 1'b1;
      end
      if (rd_en && addr == 2'd2) begin m_avail = 0; m_irq[1] = 1'b0; end
      if (m_arm && cyc == m_rxa + 2) begin
        m_arm = 0;
        if (m_on && m_rxen) begin m_rxb = 1; m_rxe = cyc + (19*CPB)/2; end
      end
      if (m_rxb && cyc == m_rxe) begin
        m_rxb = 0;
        if (m_rxbad) begin m_ferr = 1; m_irq[0] = 1'b1; end
        if (!o_avail) begin m_rxbuf = m_rxbyte; m_avail = 1; m_irq[1] = 1'b1; end
      end
      if (!m_on) begin
        m_irq[2:1] = 2'b00; m_avail = 0; m_ferr = 0; m_perr = 0; m_full = 0; m_empty = 1;
      end
      if (!m_rxen) begin m_irq[1] = 1'b0; m_avail = 0; m_ferr = 0; m_perr = 0; end
      if (!m_txen) begin m_irq[2] = 1'b0; m_full = 0; m_empty = 1; end
    end
  end

  function automatic logic model_txd();
    int idx;
    if (!m_txb) return 1'b1;
    idx = (cyc - m_txs) / CPB;
    if (idx == 0) return 1'b0;
    if (idx <= 8) return m_txbyte[idx-1];
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R3/R12 txd line", {7'b0, txd}, {7'b0, model_txd()});
      chk("R14 irq vector (R4 R5 R8)", {5'b0, irq}, {5'b0, m_irq});
      chk("R2 rdata", rdata, m_rdata);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [7:0] exp);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit good);
    @(negedge clk);
    rxd = 1'b0; m_rxa = cyc + 1; m_rxbyte = b; m_rxbad = !good; m_arm = 1'b1;
    for (int i = 0; i < 8; i++) begin
      repeat (CPB) @(negedge clk);
      rxd = b[i];
    end
    repeat (CPB) @(negedge clk); rxd = good;
    repeat (CPB) @(negedge clk); rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (CLK_PERIOD * 0 + 100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq after reset", {5'b0, irq}, 8'h00);
    chk("R1 txd after reset", {7'b0, txd}, 8'h01);
    rd(2'd1, "R1 status after reset", 8'hC0);
    rd(2'd0, "R1 control after reset", 8'h00);
    // R2 enable and read back
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h03);
    rd(2'd1, "R2 status layout", 8'hC3);
    rd(2'd0, "R2 control bit", 8'h01);
    // R3 transmit, second write while busy ignored
    wr(2'd3, 8'hA5);
    rd(2'd1, "R3 busy set empty clear", 8'hA3);
    wr(2'd3, 8'h11);
    repeat (10*CPB) @(negedge clk);
    rd(2'd1, "R4 busy cleared empty set", 8'hC3);
    chk("R4 transmit irq", {7'b0, irq[2]}, 8'h01);
    // R5 R13 clean receive with mid-frame idle check
    fork
      send_frame(8'h3C, 1'b1);
      begin repeat (20) @(negedge clk); rd(2'd1, "R13 receiver busy mid-frame", 8'h43); end
    join
    chk("R5 receive irq", {7'b0, irq[1]}, 8'h01);
    rd(2'd1, "R5 data available", 8'hC7);
    rd(2'd2, "R7 read byte", 8'h3C);
    chk("R7 receive irq cleared", {7'b0, irq[1]}, 8'h00);
    // R6 second frame dropped while holder full
    send_frame(8'h5A, 1'b1);
    send_frame(8'h99, 1'b1);
    rd(2'd2, "R6 first byte kept", 8'h5A);
    // R8 framing error, byte still stored
    send_frame(8'hF0, 1'b0);
    chk("R8 error irq", {7'b0, irq[0]}, 8'h01);
    rd(2'd1, "R8 framing flag and data", 8'hCF);
    rd(2'd2, "R8 byte stored", 8'hF0);
    // R9 partial then full error clear
    wr(2'd1, 8'h0B);
    rd(2'd1, "R9 flag kept when written 1", 8'hCB);
    chk("R9 error irq kept", {7'b0, irq[0]}, 8'h01);
    wr(2'd1, 8'h03);
    chk("R9 error irq cleared", {7'b0, irq[0]}, 8'h00);
    rd(2'd1, "R9 flag cleared", 8'hC3);
    // R12 transmit disabled mid-frame
    wr(2'd3, 8'h3C);
    repeat (25) @(negedge clk);
    wr(2'd1, 8'h01);
    chk("R12 line idle", {7'b0, txd}, 8'h01);
    chk("R12 transmit irq cleared", {7'b0, irq[2]}, 8'h00);
    rd(2'd1, "R12 empty set busy clear", 8'hC1);
    // R11 receive disabled with a byte held
    wr(2'd1, 8'h03);
    send_frame(8'h77, 1'b1);
    chk("R11 receive irq before disable", {7'b0, irq[1]}, 8'h01);
    wr(2'd1, 8'h02);
    chk("R11 receive irq cleared", {7'b0, irq[1]}, 8'h00);
    rd(2'd1, "R11 data available cleared", 8'hC2);
    send_frame(8'h66, 1'b1);
    rd(2'd1, "R11 frame ignored while disabled", 8'hC2);
    // R10 channel off with byte held and frame in flight
    wr(2'd1, 8'h03);
    send_frame(8'h42, 1'b1);
    wr(2'd3, 8'h81);
    repeat (30) @(negedge clk);
    wr(2'd0, 8'h00);
    chk("R10 irq all quiet", {5'b0, irq}, 8'h00);
    chk("R10 line idle", {7'b0, txd}, 8'h01);
    rd(2'd1, "R10 forced flags", 8'hC3);
    send_frame(8'h24, 1'b1);
    chk("R10 no receive while off", {7'b0, irq[1]}, 8'h00);
    wr(2'd3, 8'h55);
    repeat (3) @(negedge clk);
    chk("R3 write ignored while off", {7'b0, txd}, 8'h01);
    rd(2'd2, "R10 holder keeps old byte", 8'h42);
    // R5 back on
    wr(2'd0, 8'h01);
    send_frame(8'h24, 1'b1);
    rd(2'd2, "R5 receive after re-enable", 8'h24);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule